// File: doc/BRIEF.md
# Quadratic Interpolating Ramp Generator

This block produces a time-varying setpoint for device electronics from a small number of segment descriptions written by a controller. Each segment carries a start value, a first difference, a second difference, a left-shift amount for both differences, a step count and a mode bit. On every sample tick the generator advances a pair of cascaded accumulators, so the output traces a second-order arithmetic progression. In linear mode the second difference is forced to zero and the output becomes a straight ramp.

A one-deep holding register accepts the next segment while the current one runs. The held segment is taken on the first tick after the running segment has used up its steps, so consecutive segments follow each other with no idle tick. If nothing is waiting at that point, the output freezes and an underrun flag is raised. The running value is kept to 40 bits and clamps at its signed limits. The 24-bit output is the top slice of that value, so it never wraps.

Top module: `qramp_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_val` = 0, `seg_done` = 0, `underrun` = 0 and `load_ready` = 1, which means the holding register is empty.
- R2: A segment is captured into the holding register at a clock edge where `load_valid` and `load_ready` are both 1. `load_ready` then stays 0 until a tick takes the segment. An offer made while `load_ready` is 0 is ignored and does not replace the held segment.
- R3: A tick on which the block is idle or has finished its segment, and the holding register is full, starts the held segment. After that edge `out_val` equals the segment's start value, and the holding register is empty.
- R4: The 40-bit value holds the start value in bits 39:16, and `out_val` is bits 39:16 of the value. Both differences are sign-extended from 24 to 40 bits and then shifted left by `load_shift`. On each advancing tick the value gains the first difference and the first difference gains the second difference. Both additions use the values from before the tick.
- R5: With `load_lin` = 1 (linear mode) the second difference is taken as zero whatever `load_d2` holds, so the output changes by a constant amount per tick.
- R6: A segment with a step count of N advances on exactly N ticks. `seg_done` is high for one cycle after the tick that takes the remaining count to zero. For N = 0 it is high after the starting tick itself.
- R7: When the holding register is full, the first tick after a segment's last step starts the next segment, so no tick is lost between segments.
- R8: A tick on which the segment has finished and the holding register is empty leaves `out_val` unchanged and sets `underrun`. `underrun` stays set, and the output stays held, until a later tick starts a new segment.
- R9: The accumulators clamp at the signed 40-bit limits instead of wrapping, so `out_val` stops at 0x7FFFFF or 0x800000.
- R10: On a cycle without `tick`, `out_val` does not change and `seg_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe, one cycle per output sample |
| load_valid | input | 1 | Offer of a segment to the holding register |
| load_ready | output | 1 | Holding register empty and able to accept |
| load_start | input | 24 | Signed start value at output scale |
| load_d1 | input | 24 | Signed first difference before shifting |
| load_d2 | input | 24 | Signed second difference before shifting |
| load_steps | input | 16 | Number of advancing ticks in the segment |
| load_shift | input | 4 | Left shift applied to both differences |
| load_lin | input | 1 | 1 selects linear mode, 0 selects quadratic mode |
| out_val | output | 24 | Signed ramp output |
| seg_done | output | 1 | One-cycle pulse when a segment's count reaches zero |
| underrun | output | 1 | Held output because no segment was waiting |

## Verification
The assertions assume that `tick` is a one-cycle strobe and that `rst` is held for at least two edges at start-up. The bench always drives `tick` high for one cycle and then low for one cycle, and applies reset for several cycles. The checks also assume that a shifted difference fits in 40 bits. The bench uses shift amounts and coefficients that meet this, and it tests clamping only through the sum of many steps. Segments are offered only when the bench's own model says the holding register is empty, except in the one directed test where an offer is made on purpose while the register is full.

// File: rtl/qramp_pkg.sv
package qramp_pkg;
   localparam int unsigned DEF_OUT_W  = 24;
   localparam int unsigned DEF_COEF_W = 24;
   localparam int unsigned DEF_ACC_W  = 40;
   localparam int unsigned DEF_CNT_W  = 16;
   localparam int unsigned DEF_SH_W   = 4;

   typedef enum logic {
      MODE_QUAD = 1'b0,
      MODE_LIN  = 1'b1
   } ramp_mode_e;
endpackage

// File: rtl/qramp_shadow.sv
module qramp_shadow #(
   parameter int unsigned OUT_W  = 24,
   parameter int unsigned COEF_W = 24,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned SH_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [OUT_W-1:0]  wr_start,
   input  logic [COEF_W-1:0] wr_d1,
   input  logic [COEF_W-1:0] wr_d2,
   input  logic [CNT_W-1:0]  wr_steps,
   input  logic [SH_W-1:0]   wr_shift,
   input  logic              wr_lin,
   input  logic              take,
   output logic              full,
   output logic [OUT_W-1:0]  hd_start,
   output logic [COEF_W-1:0] hd_d1,
   output logic [COEF_W-1:0] hd_d2,
   output logic [CNT_W-1:0]  hd_steps,
   output logic [SH_W-1:0]   hd_shift,
   output qramp_pkg::ramp_mode_e hd_mode
);
   always_ff @(posedge clk) begin
      if (rst) begin
         full     <= 1'b0;
         hd_start <= '0;
         hd_d1    <= '0;
         hd_d2    <= '0;
         hd_steps <= '0;
         hd_shift <= '0;
         hd_mode  <= qramp_pkg::MODE_QUAD;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_valid && !full) begin
         full     <= 1'b1;
         hd_start <= wr_start;
         hd_d1    <= wr_d1;
         hd_d2    <= wr_d2;
         hd_steps <= wr_steps;
         hd_shift <= wr_shift;
         hd_mode  <= wr_lin ? qramp_pkg::MODE_LIN : qramp_pkg::MODE_QUAD;
      end
   end
endmodule

// File: rtl/qramp_seq.sv
module qramp_seq #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             pend,
   input  logic [CNT_W-1:0] pend_steps,
   output logic             start_seg,
   output logic             advance,
   output logic             done,
   output logic             starved
);
   logic             running;
   logic [CNT_W-1:0] remain;
   logic             finished;

   assign finished  = !running || (remain == '0);
   assign start_seg = tick && pend && finished;
   assign advance   = tick && running && (remain != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         remain  <= '0;
         done    <= 1'b0;
         starved <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_seg) begin
            running <= 1'b1;
            remain  <= pend_steps;
            done    <= (pend_steps == '0);
            starved <= 1'b0;
         end else if (advance) begin
            remain <= remain - CNT_W'(1);
            done   <= (remain == CNT_W'(1));
         end else if (tick && running) begin
            running <= 1'b0;
            starved <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/qramp_acc.sv
module qramp_acc #(
   parameter int unsigned OUT_W   = 24,
   parameter int unsigned COEF_W  = 24,
   parameter int unsigned ACC_W   = 40,
   parameter int unsigned SH_W    = 4,
   parameter bit          QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_seg,
   input  logic              advance,
   input  logic [OUT_W-1:0]  seg_start,
   input  logic [COEF_W-1:0] seg_d1,
   input  logic [COEF_W-1:0] seg_d2,
   input  logic [SH_W-1:0]   seg_shift,
   input  qramp_pkg::ramp_mode_e seg_mode,
   output logic [OUT_W-1:0]  value_hi
);
   localparam int unsigned FRAC_W = ACC_W - OUT_W;
   localparam int unsigned EXT_W  = ACC_W - COEF_W;

   logic [ACC_W-1:0] val_q, slope_q, curv_q;
   logic [ACC_W-1:0] start_ext, d1_ext, d2_ext;

   function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
      logic [ACC_W:0] s;
      s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
      if (s[ACC_W] != s[ACC_W-1])
         sat_add = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      else
         sat_add = s[ACC_W-1:0];
   endfunction

   assign start_ext = {seg_start, {FRAC_W{1'b0}}};
   assign d1_ext    = {{EXT_W{seg_d1[COEF_W-1]}}, seg_d1} << seg_shift;
   assign d2_ext    = {{EXT_W{seg_d2[COEF_W-1]}}, seg_d2} << seg_shift;

   always_ff @(posedge clk) begin
      if (rst) begin
         val_q   <= '0;
         slope_q <= '0;
      end else if (start_seg) begin
         val_q   <= start_ext;
         slope_q <= d1_ext;
      end else if (advance) begin
         val_q   <= sat_add(val_q, slope_q);
         slope_q <= sat_add(slope_q, curv_q);
      end
   end

   generate
      if (QUAD_EN) begin : g_quad
         always_ff @(posedge clk) begin
            if (rst)
               curv_q <= '0;
            else if (start_seg)
               curv_q <= (seg_mode == qramp_pkg::MODE_LIN) ? '0 : d2_ext;
         end
      end else begin : g_lin_only
         assign curv_q = '0;
      end
   endgenerate

   assign value_hi = val_q[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/qramp_gen.sv
module qramp_gen #(
   parameter int unsigned OUT_W   = qramp_pkg::DEF_OUT_W,
   parameter int unsigned COEF_W  = qramp_pkg::DEF_COEF_W,
   parameter int unsigned ACC_W   = qramp_pkg::DEF_ACC_W,
   parameter int unsigned CNT_W   = qramp_pkg::DEF_CNT_W,
   parameter int unsigned SH_W    = qramp_pkg::DEF_SH_W,
   parameter bit          QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              load_valid,
   output logic              load_ready,
   input  logic [OUT_W-1:0]  load_start,
   input  logic [COEF_W-1:0] load_d1,
   input  logic [COEF_W-1:0] load_d2,
   input  logic [CNT_W-1:0]  load_steps,
   input  logic [SH_W-1:0]   load_shift,
   input  logic              load_lin,
   output logic [OUT_W-1:0]  out_val,
   output logic              seg_done,
   output logic              underrun
);
   generate
      if (ACC_W <= OUT_W) begin : g_bad_acc
         $error("ACC_W must exceed OUT_W");
      end
      if (COEF_W > ACC_W) begin : g_bad_coef
         $error("COEF_W must not exceed ACC_W");
      end
      if (CNT_W < 1 || SH_W < 1) begin : g_bad_cnt
         $error("CNT_W and SH_W must be at least 1");
      end
   endgenerate

   logic              pend, start_seg, advance;
   logic [OUT_W-1:0]  h_start;
   logic [COEF_W-1:0] h_d1, h_d2;
   logic [CNT_W-1:0]  h_steps;
   logic [SH_W-1:0]   h_shift;
   qramp_pkg::ramp_mode_e h_mode;

   qramp_shadow #(.OUT_W(OUT_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_shadow (
      .clk(clk), .rst(rst),
      .wr_valid(load_valid), .wr_start(load_start), .wr_d1(load_d1), .wr_d2(load_d2),
      .wr_steps(load_steps), .wr_shift(load_shift), .wr_lin(load_lin),
      .take(start_seg), .full(pend),
      .hd_start(h_start), .hd_d1(h_d1), .hd_d2(h_d2), .hd_steps(h_steps),
      .hd_shift(h_shift), .hd_mode(h_mode)
   );

   qramp_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .tick(tick), .pend(pend), .pend_steps(h_steps),
      .start_seg(start_seg), .advance(advance), .done(seg_done), .starved(underrun)
   );

   qramp_acc #(.OUT_W(OUT_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SH_W(SH_W),
               .QUAD_EN(QUAD_EN)) u_acc (
      .clk(clk), .rst(rst), .start_seg(start_seg), .advance(advance),
      .seg_start(h_start), .seg_d1(h_d1), .seg_d2(h_d2), .seg_shift(h_shift),
      .seg_mode(h_mode), .value_hi(out_val)
   );

   assign load_ready = !pend;
endmodule

// File: rtl/qramp_chk.sv
module qramp_chk #(
   parameter int unsigned OUT_W = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             load_valid,
   input logic             load_ready,
   input logic [OUT_W-1:0] out_val,
   input logic             seg_done,
   input logic             underrun
);
   logic pv;
   always_ff @(posedge clk) begin
      if (rst) pv <= 1'b0;
      else     pv <= 1'b1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (out_val == '0 && !seg_done && !underrun && load_ready));

   // R2
   held_full_chk: assert property (@(posedge clk) disable iff (rst || !pv)
      (!load_ready && !tick) |=> !load_ready);

   // R3
   take_on_tick_chk: assert property (@(posedge clk) disable iff (rst || !pv)
      $rose(load_ready) |-> $past(tick));

   // R6
   done_after_tick_chk: assert property (@(posedge clk) disable iff (rst || !pv)
      seg_done |-> $past(tick));

   // R8
   starve_hold_chk: assert property (@(posedge clk) disable iff (rst || !pv)
      (underrun && $past(underrun)) |-> $stable(out_val));

   // R10
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst || !pv)
      !$past(tick) |-> ($stable(out_val) && !seg_done));

   // R2
   valid_known_chk: assert property (@(posedge clk) disable iff (rst)
      !$isunknown(load_valid));
endmodule

bind qramp_gen qramp_chk #(.OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .load_valid(load_valid),
   .load_ready(load_ready), .out_val(out_val), .seg_done(seg_done),
   .underrun(underrun)
);

// File: tb/sim_qramp_gen.sv
`timescale 1ns/100ps
module sim_qramp_gen;
   typedef struct packed {
      logic [23:0] start;
      logic [23:0] d1;
      logic [23:0] d2;
      logic [15:0] steps;
      logic [3:0]  shift;
      logic        lin;
   } seg_t;

   localparam int NSEG = 6;
   localparam seg_t VEC [NSEG] = '{
      '{24'h000000, 24'h000100, 24'h000010, 16'd5,  4'd4,  1'b0},
      '{24'hFFFC18, 24'hFFFFFD, 24'h000055, 16'd4,  4'd8,  1'b1},
      '{24'h7FFF00, 24'h000040, 24'h000010, 16'd20, 4'd12, 1'b0},
      '{24'h800080, 24'hFFFF80, 24'h000000, 16'd20, 4'd12, 1'b0},
      '{24'h123456, 24'h000777, 24'h000333, 16'd0,  4'd3,  1'b0},
      '{24'h000000, 24'h000020, 24'hFFFFF8, 16'd6,  4'd10, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        load_valid = 1'b0;
   logic        load_ready;
   logic [23:0] load_start = '0, load_d1 = '0, load_d2 = '0;
   logic [15:0] load_steps = '0;
   logic [3:0]  load_shift = '0;
   logic        load_lin = 1'b0;
   logic [23:0] out_val;
   logic        seg_done, underrun;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   // bench model state
   longint mv, md1, md2;
   int     mcnt;
   bit     mrun, mfull, mdone, munder;
   seg_t   mhold;

   always #2.5 clk = ~clk;

   qramp_gen u0 (
      .clk(clk), .rst(rst), .tick(tick), .load_valid(load_valid), .load_ready(load_ready),
      .load_start(load_start), .load_d1(load_d1), .load_d2(load_d2),
      .load_steps(load_steps), .load_shift(load_shift), .load_lin(load_lin),
      .out_val(out_val), .seg_done(seg_done), .underrun(underrun)
   );

   localparam longint LIM_HI = 64'sh0000_007F_FFFF_FFFF;
   localparam longint LIM_LO = -64'sh0000_0080_0000_0000;

   function automatic longint sat40(input longint x);
      if (x > LIM_HI) return LIM_HI;
      if (x < LIM_LO) return LIM_LO;
      return x;
   endfunction

   function automatic logic [23:0] exp_out();
      return mv[39:16];
   endfunction

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      mv = 0; md1 = 0; md2 = 0; mcnt = 0;
      mrun = 0; mfull = 0; mdone = 0; munder = 0;
   endtask

   task automatic offer(input seg_t s);
      @(negedge clk);
      load_valid = 1'b1;
      load_start = s.start; load_d1 = s.d1; load_d2 = s.d2;
      load_steps = s.steps; load_shift = s.shift; load_lin = s.lin;
      if (!mfull) begin
         mfull = 1'b1;
         mhold = s;
      end
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   // one tick, model update, then compare at the following falling edge
   task automatic step(input string tag);
      string t;
      bit started;
      @(negedge clk);
      tick = 1'b1;
      started = 1'b0;
      mdone = 1'b0;
      if (!mrun || mcnt == 0) begin
         if (mfull) begin
            mv  = longint'($signed(mhold.start)) <<< 16;
            md1 = longint'($signed(mhold.d1)) <<< mhold.shift;
            md2 = mhold.lin ? 0 : (longint'($signed(mhold.d2)) <<< mhold.shift);
            mcnt = int'(mhold.steps);
            mdone = (mhold.steps == 0);
            mrun = 1'b1; munder = 1'b0; mfull = 1'b0;
            started = 1'b1;
         end else if (mrun) begin
            mrun = 1'b0; munder = 1'b1;
         end
      end else begin
         mv  = sat40(mv + md1);
         md1 = sat40(md1 + md2);
         mcnt--;
         mdone = (mcnt == 0);
      end
      @(negedge clk);
      tick = 1'b0;
      if (started) t = "R3_R7";
      else if (munder) t = "R8";
      else if (exp_out() == 24'h7FFFFF || exp_out() == 24'h800000) t = "R9";
      else t = tag;
      chk(t, out_val, exp_out());
      chk("R6", {23'b0, seg_done}, {23'b0, mdone});
      chk("R8", {23'b0, underrun}, {23'b0, munder});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1", out_val, 24'h0);
      chk("R1", {22'b0, seg_done, underrun}, 24'h0);
      chk("R1", {23'b0, load_ready}, 24'h1);

      // table walk: back-to-back segments, R4 R5 R9 R6 R7
      offer(VEC[0]);
      chk("R2", {23'b0, load_ready}, 24'h0);
      step("R4");
      for (int i = 1; i < NSEG; i++) begin
         offer(VEC[i]);
         for (int k = 0; k < int'(VEC[i-1].steps); k++)
            step(VEC[i-1].lin ? "R5" : "R4");
         step("R7");
      end
      for (int k = 0; k < int'(VEC[NSEG-1].steps); k++) step("R4");
      // R8 underrun, held for further ticks
      step("R8");
      step("R8");
      chk("R8", {23'b0, underrun}, 24'h1);

      // R10 no tick: output and done hold
      repeat (5) @(negedge clk);
      chk("R10", out_val, exp_out());
      chk("R10", {23'b0, seg_done}, 24'h0);

      // R3 recovery from underrun
      offer(VEC[1]);
      step("R3");
      for (int k = 0; k < 4; k++) step("R5");

      // R2 offer while full is ignored
      do_reset();
      chk("R1", out_val, 24'h0);
      offer(VEC[4]);
      offer(VEC[0]);
      chk("R2", {23'b0, load_ready}, 24'h0);
      step("R2");
      chk("R2", out_val, 24'h123456);
      step("R8");
      chk("R2", {23'b0, underrun}, 24'h1);

      // R1 reset in the middle of a segment
      offer(VEC[2]);
      step("R3");
      step("R4");
      do_reset();
      chk("R1", out_val, 24'h0);
      chk("R1", {22'b0, seg_done, underrun}, 24'h0);
      chk("R1", {23'b0, load_ready}, 24'h1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule